// File: doc/BRIEF.md
# Data-Dependent Vector Truncation Sequencer

This block steps through the elements of a vector operation strictly in order, from element 0 up to the current vector length minus one. Each element result arrives on a valid/ready stream. The block derives a four-bit condition field from the result, picks one bit of that field and compares it with an invert control. The first element that fails this comparison ends the loop. The block then reports a shorter vector length that covers only the passing elements, or the passing elements plus the failing one. The result may be zero. If no element fails, the length is left as it was.

For each accepted element the block drives two write enables: one for the element result and one for its condition field. The execution datapath uses these to commit or drop the element. A run begins with a start pulse and ends with a one-cycle done pulse, which comes with the new length on a held output.

Back-pressure rules: `res_ready_o` is high in every cycle of a run and low at all other times. An element is taken in a cycle where `res_valid_i` and `res_ready_o` are both high. The producer may leave gaps by dropping valid, and the block never withholds ready in the middle of a run. Valid is ignored outside a run. Once the run has ended, because of a failure or because the length is used up, ready falls and no further element is taken.

Top module: `vec_trunc_ctrl`

## Requirements
- R1: After reset, `res_ready_o`, `done_o` and `new_vl_o` are all zero.
- R2: The block samples `start_i` only when idle. At that point it latches `vlen_i` and the mode inputs. Changes to them during a run have no effect, and a start during a run is ignored. `res_ready_o` stays high for the whole run. On each accepted element, `elem_idx_o` gives that element's index, counting up from 0.
- R3: On an accepted element, `cond_o` gives the condition field of `res_data_i`, read as a signed 64-bit value: bit 3 is negative (sign set), bit 2 is positive (nonzero with sign clear), bit 1 is zero (all bits clear), and bit 0 is always 0.
- R4: The tested bit is chosen by `csel_i` (0 = bit 3, 1 = bit 2, 2 = bit 1, 3 = bit 0) only when `rc_i`=1 and `cmp_only_i`=0. In every other case the zero bit (bit 1) is tested. An element fails when the tested bit equals `inv_i`.
- R5: On a failing element the loop ends. That element's result is not written (`res_we_o`=0), and no later element is accepted. A passing element with `cmp_only_i`=0 has `res_we_o`=1.
- R6: After a failure at index k, `new_vl_o` is k, or k+1 when `incl_i`=1 and `rc_i`=0. `incl_i` has no effect when `rc_i`=1.
- R7: A failure at element 0 with the inclusive option off gives `new_vl_o`=0.
- R8: When `cmp_only_i`=1, `res_we_o` is never asserted, and `cond_we_o` is asserted for every accepted element, including the failing one.
- R9: `cond_we_o` is asserted on an accepted element exactly when `rc_i`=1 or `cmp_only_i`=1.
- R10: If no element fails, `new_vl_o` equals the latched length, and `done_o` rises in the cycle after element length-1 is accepted.
- R11: A start with `vlen_i`=0 raises `done_o` in the next cycle with `new_vl_o`=0, and no element is accepted.
- R12: `done_o` is a one-cycle pulse. `new_vl_o` changes only in the cycle where `done_o` is high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| vlen_i | input | VLW (7) | Vector length at start, 0..MAXVL |
| inv_i | input | 1 | Invert: 0 expects the tested bit set, 1 expects it clear |
| csel_i | input | 2 | Condition bit select, used when rc_i=1 and cmp_only_i=0 |
| incl_i | input | 1 | Count the failing element in the new length (when rc_i=0) |
| cmp_only_i | input | 1 | Write conditions only, never results |
| rc_i | input | 1 | Record condition fields for every element |
| res_valid_i | input | 1 | Element result valid |
| res_data_i | input | DW (64) | Element result |
| res_ready_o | output | 1 | Ready to accept an element (high during a run) |
| elem_idx_o | output | VLW (7) | Index of the current element |
| res_we_o | output | 1 | Commit the element result |
| cond_we_o | output | 1 | Commit the element condition field |
| cond_o | output | 4 | Condition field of the current element |
| new_vl_o | output | VLW (7) | Resulting vector length, held |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume that `vlen_i` never exceeds MAXVL when a start is taken, and that the mode inputs mean something only at that start. They also rely on the stream rule that a write enable can appear only in a cycle where an element is taken. The stimulus keeps every length at or below 64. It changes the mode inputs and `vlen_i` right after each start, and it pulses start in the middle of runs, so that sampling and the ignore rule are both exercised. The stimulus also inserts valid gaps, so that cycles with ready high and no accepted element are covered.

// File: rtl/ffv_pkg.sv
package ffv_pkg;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic ov;
  } cond_t;

  typedef enum logic [1:0] {
    SEL_LT = 2'd0,
    SEL_GT = 2'd1,
    SEL_EQ = 2'd2,
    SEL_OV = 2'd3
  } csel_e;

  typedef struct packed {
    logic       inv;
    logic [1:0] sel;
    logic       incl;
    logic       cmp_only;
    logic       rc;
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  function automatic logic pick_bit(cond_t c, logic [1:0] s);
    logic b;
    case (s)
      SEL_LT:  b = c.lt;
      SEL_GT:  b = c.gt;
      SEL_EQ:  b = c.eq;
      default: b = c.ov;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ffv_cond_gen.sv
module ffv_cond_gen
  import ffv_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] data_i,
  output cond_t         cond_o
);
  logic zero;

  // zero, sign and positive flags of the signed element result
  assign zero      = (data_i == '0);
  assign cond_o.lt = data_i[DW-1];
  assign cond_o.eq = zero;
  assign cond_o.gt = ~data_i[DW-1] & ~zero;
  assign cond_o.ov = 1'b0;
endmodule

// File: rtl/ffv_cond_test.sv
module ffv_cond_test
  import ffv_pkg::*;
(
  input  cond_t      cond_i,
  input  logic [1:0] sel_i,
  input  logic       use_sel_i,
  input  logic       inv_i,
  output logic       fail_o
);
  logic tested;

  // the zero bit is tested unless the selector is enabled
  always_comb begin
    if (use_sel_i) tested = pick_bit(cond_i, sel_i);
    else           tested = cond_i.eq;
  end

  assign fail_o = (tested == inv_i);
endmodule

// File: rtl/ffv_seq.sv
module ffv_seq
  import ffv_pkg::*;
#(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VLW-1:0] vlen_i,
  input  mode_t          mode_i,
  input  logic           valid_i,
  input  logic           fail_i,
  output logic           ready_o,
  output logic           acc_o,
  output logic [VLW-1:0] idx_o,
  output mode_t          mode_o,
  output logic [VLW-1:0] new_vl_o,
  output logic           done_o
);
  st_e            st;
  logic [VLW-1:0] idx_q;
  logic [VLW-1:0] vl_q;
  logic [VLW-1:0] nvl_q;
  mode_t          mode_q;
  logic           last;
  logic           incl_eff;

  assign ready_o  = (st == ST_RUN);
  assign acc_o    = ready_o & valid_i;
  assign last     = (idx_q == vl_q - VLW'(1));
  assign incl_eff = mode_q.incl & ~mode_q.rc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx_q  <= '0;
      vl_q   <= '0;
      nvl_q  <= '0;
      mode_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            mode_q <= mode_i;
            vl_q   <= vlen_i;
            idx_q  <= '0;
            if (vlen_i == '0) begin
              nvl_q <= '0;
              st    <= ST_FIN;
            end else begin
              st <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (acc_o) begin
            if (fail_i) begin
              nvl_q <= idx_q + VLW'(incl_eff);
              st    <= ST_FIN;
            end else if (last) begin
              nvl_q <= vl_q;
              st    <= ST_FIN;
            end else begin
              idx_q <= idx_q + VLW'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idx_o    = idx_q;
  assign mode_o   = mode_q;
  assign new_vl_o = nvl_q;
  assign done_o   = (st == ST_FIN);
endmodule

// File: rtl/vec_trunc_ctrl.sv
module vec_trunc_ctrl
  import ffv_pkg::*;
#(
  parameter int DW    = 64,
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VLW-1:0] vlen_i,
  input  logic           inv_i,
  input  logic [1:0]     csel_i,
  input  logic           incl_i,
  input  logic           cmp_only_i,
  input  logic           rc_i,
  input  logic           res_valid_i,
  input  logic [DW-1:0]  res_data_i,
  output logic           res_ready_o,
  output logic [VLW-1:0] elem_idx_o,
  output logic           res_we_o,
  output logic           cond_we_o,
  output logic [3:0]     cond_o,
  output logic [VLW-1:0] new_vl_o,
  output logic           done_o
);
  mode_t mode_in;
  mode_t mode_q;
  cond_t cond;
  logic  fail;
  logic  acc;
  logic  use_sel;

  assign mode_in.inv      = inv_i;
  assign mode_in.sel      = csel_i;
  assign mode_in.incl     = incl_i;
  assign mode_in.cmp_only = cmp_only_i;
  assign mode_in.rc       = rc_i;

  ffv_cond_gen #(.DW(DW)) u_gen (
    .data_i (res_data_i),
    .cond_o (cond)
  );

  assign use_sel = mode_q.rc & ~mode_q.cmp_only;

  ffv_cond_test u_test (
    .cond_i    (cond),
    .sel_i     (mode_q.sel),
    .use_sel_i (use_sel),
    .inv_i     (mode_q.inv),
    .fail_o    (fail)
  );

  ffv_seq #(.MAXVL(MAXVL)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .vlen_i   (vlen_i),
    .mode_i   (mode_in),
    .valid_i  (res_valid_i),
    .fail_i   (fail),
    .ready_o  (res_ready_o),
    .acc_o    (acc),
    .idx_o    (elem_idx_o),
    .mode_o   (mode_q),
    .new_vl_o (new_vl_o),
    .done_o   (done_o)
  );

  assign res_we_o  = acc & ~fail & ~mode_q.cmp_only;
  assign cond_we_o = acc & (mode_q.rc | mode_q.cmp_only);
  assign cond_o    = cond;
endmodule

// File: rtl/ffv_chk.sv
module ffv_chk #(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [VLW-1:0] vlen_i,
  input logic           cmp_only_i,
  input logic           res_valid_i,
  input logic           res_ready_o,
  input logic           res_we_o,
  input logic           cond_we_o,
  input logic [VLW-1:0] new_vl_o,
  input logic           done_o
);
  logic           idle;
  logic [VLW-1:0] vl_s;
  logic           cmp_s;
  logic [VLW:0]   cnt;

  assign idle = ~res_ready_o & ~done_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_s  <= '0;
      cmp_s <= 1'b0;
      cnt   <= '0;
    end else if (start_i && idle) begin
      vl_s  <= vlen_i;
      cmp_s <= cmp_only_i;
      cnt   <= '0;
    end else if (res_valid_i && res_ready_o) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_vl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle) |-> (int'(vlen_i) <= MAXVL));

  a_r2_we_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we_o || cond_we_o) |-> (res_valid_i && res_ready_o));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {1'b0, vl_s});

  a_r8_no_result_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_s && res_ready_o) |-> !res_we_o);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r12_nvl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(new_vl_o));

  a_r10_nvl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (new_vl_o <= vl_s));

  a_r11_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle && vlen_i == '0) |=> (done_o && new_vl_o == '0));
endmodule

bind vec_trunc_ctrl ffv_chk #(.MAXVL(MAXVL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .vlen_i      (vlen_i),
  .cmp_only_i  (cmp_only_i),
  .res_valid_i (res_valid_i),
  .res_ready_o (res_ready_o),
  .res_we_o    (res_we_o),
  .cond_we_o   (cond_we_o),
  .new_vl_o    (new_vl_o),
  .done_o      (done_o)
);

// File: tb/vec_trunc_ctrl_test.sv
`timescale 1ns/1ps
module vec_trunc_ctrl_test;
  localparam int DW    = 64;
  localparam int MAXVL = 64;
  localparam int VLW   = $clog2(MAXVL + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [VLW-1:0] vlen;
  logic           inv, incl, cmp_only, rc;
  logic [1:0]     csel;
  logic           valid;
  logic [DW-1:0]  data;
  logic           ready, res_we, cond_we, done;
  logic [VLW-1:0] idx, new_vl;
  logic [3:0]     cond;

  int errs   = 0;
  int checks = 0;
  logic [63:0] vals [MAXVL];

  always #2.5 clk = ~clk;

  vec_trunc_ctrl #(.DW(DW), .MAXVL(MAXVL)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vlen_i(vlen),
    .inv_i(inv), .csel_i(csel), .incl_i(incl), .cmp_only_i(cmp_only),
    .rc_i(rc), .res_valid_i(valid), .res_data_i(data),
    .res_ready_o(ready), .elem_idx_o(idx), .res_we_o(res_we),
    .cond_we_o(cond_we), .cond_o(cond), .new_vl_o(new_vl), .done_o(done)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_cond(logic [63:0] d);
    logic n, z;
    n = d[63];
    z = (d == 64'd0);
    return {n, !n && !z, z, 1'b0};
  endfunction

  // fills: 0 positive, 1 negative; zero planted at zpos (-1 = none)
  task automatic fill(int kind, int zpos);
    for (int i = 0; i < MAXVL; i++) begin
      vals[i] = 64'(i + 1) * 64'h0000_0001_0000_0003;
      if (kind == 1) vals[i][63] = 1'b1;
      if (i == zpos) vals[i] = 64'd0;
    end
  endtask

  task automatic run_vec(int vl, bit v_inv, int v_sel, bit v_incl, bit v_cmp,
                         bit v_rc, bit gaps, bit poke, string tag);
    int  exp_nvl;
    bit  failed;
    logic [3:0] c;
    logic tb;
    @(negedge clk);
    start = 1'b1; vlen = VLW'(vl); inv = v_inv; csel = 2'(v_sel);
    incl = v_incl; cmp_only = v_cmp; rc = v_rc;
    @(negedge clk);
    start = 1'b0;
    // scramble mode after start: must be ignored (R2)
    vlen = VLW'(3); inv = ~v_inv; csel = ~csel; incl = ~v_incl;
    cmp_only = ~v_cmp; rc = ~v_rc;
    if (vl == 0) begin
      #1;
      chk({tag, " R11 done"}, done, 1);
      chk({tag, " R11 new_vl"}, new_vl, 0);
      chk({tag, " R11 ready"}, ready, 0);
      @(negedge clk); #1;
      chk({tag, " R12 done pulse"}, done, 0);
      return;
    end
    exp_nvl = vl;
    failed  = 1'b0;
    for (int i = 0; i < vl; i++) begin
      if (gaps && (i % 3 == 1)) begin
        valid = 1'b0; start = poke; vlen = VLW'(5);
        #1;
        chk({tag, " R2 ready in gap"}, ready, 1);
        chk({tag, " R2 no write in gap"}, {res_we, cond_we}, 0);
        @(negedge clk);
      end
      valid = 1'b1; data = vals[i]; start = poke;
      #1;
      c = ref_cond(vals[i]);
      if (v_rc && !v_cmp) tb = c[3 - v_sel];
      else                tb = c[1];
      failed = (tb == v_inv);
      chk({tag, " R2 ready"}, ready, 1);
      chk({tag, " R2 index"}, idx, i);
      chk({tag, " R3 cond"}, cond, c);
      chk({tag, " R5 R8 res_we"}, res_we, (!failed && !v_cmp) ? 1 : 0);
      chk({tag, " R9 cond_we"}, cond_we, (v_rc || v_cmp) ? 1 : 0);
      @(negedge clk);
      if (failed) begin
        exp_nvl = i + ((v_incl && !v_rc) ? 1 : 0);
        break;
      end
    end
    valid = 1'b0; start = 1'b0;
    #1;
    chk({tag, " R10 done after last"}, done, 1);
    chk({tag, " R6 R10 new_vl"}, new_vl, exp_nvl);
    chk({tag, " R5 ready low"}, ready, 0);
    @(negedge clk); #1;
    chk({tag, " R12 done pulse"}, done, 0);
    chk({tag, " R12 new_vl held"}, new_vl, exp_nvl);
    chk({tag, " R5 no accept after end"}, ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vlen = '0; inv = 1'b0; csel = '0;
    incl = 1'b0; cmp_only = 1'b0; rc = 1'b0; valid = 1'b0; data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready", ready, 0);
    chk("R1 done", done, 0);
    chk("R1 new_vl", new_vl, 0);
    @(negedge clk);
    rst_n = 1'b1;

    fill(1, -1);
    run_vec(8, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R10 negative all pass");
    fill(0, 5);
    run_vec(12, 1'b0, 1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6 gt fail incl ignored");
    fill(0, 4);
    run_vec(10, 1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 zero fail inclusive");
    fill(0, 0);
    run_vec(6, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 first element fails");
    fill(0, 3);
    run_vec(9, 1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8 cond only");
    run_vec(0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 zero length");
    fill(1, -1);
    run_vec(MAXVL, 1'b1, 3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4 R2 full length");
    run_vec(5, 1'b0, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 R7 ov bit fail");
    fill(0, 5);
    run_vec(6, 1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 last element fails");
    fill(1, 2);
    run_vec(7, 1'b1, 2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4 eq select");
    fill(0, -1);
    run_vec(4, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 rc0 expects zero");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule